// File: doc/BRIEF.md
# Shared-Period Three-Channel PWM Controller

The controller generates pulse-width-modulated levels on up to three pins of a 32-bit output vector. All channels share one free-running 16-bit counter and one period compare. Each channel owns a duty compare. A channel's pin starts low, toggles when the counter reaches the channel's duty value, and toggles back when the counter reaches the shared period and wraps to zero. With an active-low load, the low phase of each cycle is the "on" time.

Software-side logic sends a request carrying a pin number, a period and a pulse width. The controller binds the pin to a slot and checks that the period agrees with every other channel that is running. It then stops the counter, programs the compares and restarts the counter from zero. A pulse of zero parks the pin high, and a pulse equal to the period parks it low. Neither runs a waveform, and both leave the counter halted. Periods above 16 bits are scaled down by a common right shift of period and pulse. A one-cycle response reports the outcome.

Top module: `pwm_share_ctrl`

## Requirements
- R1: `req_ready` is high whenever no response is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the following cycle, and `req_ready` is low during that cycle. `rsp_status` is 0 for success, 1 for a bad argument and 2 for no free slot.
- R2: After reset, `pin_out` is all zero, `rsp_valid` is low and `req_ready` is high.
- R3: An accepted request whose pulse is neither zero nor equal to the period drives its pin low at the taking edge. Let n be the number of edges after the taking edge, Pc the period compare value and Dc the duty compare value. The pin then equals 1 exactly when (n mod Pc) >= Dc, so one waveform cycle lasts Pc clocks.
- R4: If the period is 2^16 or more, period and pulse are both shifted right by the smallest amount that brings the period below 2^16. The shifted values become Pc and Dc. A period below 2^16 is used unshifted.
- R5: A request with pulse zero drives its pin high, frees its slot (a later request for another pin can take it), and halts the shared counter.
- R6: A request with pulse equal to the period (and nonzero) drives its pin low, frees its slot, and halts the shared counter.
- R7: While the counter is halted, `pin_out` does not change until a request is accepted.
- R8: A request with status 1 is returned when its pulse is neither zero nor equal to its period, its period differs from the stored shared period, and some slot bound to another pin holds a nonzero pulse. Zero and full pulses skip this check. A rejected request leaves every running waveform undisturbed.
- R9: Slot choice first reuses the slot bound to the same pin. Otherwise it takes the highest-numbered slot with a zero stored pulse. If neither exists, status 2 is returned and nothing changes.
- R10: Starting a waveform restarts the shared counter at zero. The other running channels keep the level they had and continue toggling from the new count. A channel whose level was L0 at the restart reads L0 XOR ((n mod Pc) >= Dc).
- R11: A pin that no running channel drives keeps its last driven level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_pin | input | 5 | Target pin number |
| req_period | input | 32 | Period in clock cycles |
| req_pulse | input | 32 | Low-phase width in clock cycles |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_status | output | 2 | 0 success, 1 bad argument, 2 no free slot |
| pin_out | output | 32 | Pin levels |

## Verification
Status and the new level of the requested pin are due together, one edge after the taking edge. Waveform positions are counted from that same taking edge, with zero at the edge itself. The bench counts the edges since the last restart and samples every output on the falling edge, so that each expected level is a direct function of n. The level a running pin held before a restart is read on the falling edge before the request; no toggle happens on the taking edge, so that level is the channel's starting level afterwards. Halt behaviour is checked by comparing `pin_out` across twenty idle cycles.

// File: rtl/pwm_share_pkg.sv
package pwm_share_pkg;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_BADARG = 2'd1,
        ST_NOSLOT = 2'd2
    } pwm_status_e;

endpackage

// File: rtl/pwm_range_fit.sv
// Scales period and pulse by a common right shift so the period fits the counter.
module pwm_range_fit #(
    parameter int VAL_W = 32,
    parameter int CNT_W = 16
) (
    input  logic [VAL_W-1:0] period_i,
    input  logic [VAL_W-1:0] pulse_i,
    output logic [CNT_W-1:0] per_cmp_o,
    output logic [CNT_W-1:0] duty_cmp_o
);
    localparam int MAX_SH = VAL_W - CNT_W;
    localparam int SH_W   = $clog2(MAX_SH + 1);

    logic [SH_W-1:0] sh;

    always_comb begin
        sh = SH_W'(MAX_SH);
        for (int s = MAX_SH; s >= 0; s--) begin
            if (((period_i >> s) >> CNT_W) == '0) begin
                sh = SH_W'(s);
            end
        end
        per_cmp_o  = CNT_W'(period_i >> sh);
        duty_cmp_o = CNT_W'(pulse_i >> sh);
    end

endmodule

// File: rtl/pwm_slot_alloc.sv
// Slot lookup and shared-period clash detection.
module pwm_slot_alloc #(
    parameter int NUM_SLOTS = 3,
    parameter int PIN_W     = 5,
    parameter int VAL_W     = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [PIN_W-1:0]                  pin_i,
    input  logic [VAL_W-1:0]                  period_i,
    input  logic [VAL_W-1:0]                  shared_per_i,
    input  logic [NUM_SLOTS-1:0][PIN_W-1:0]   slot_pin_i,
    input  logic [NUM_SLOTS-1:0][VAL_W-1:0]   slot_pulse_i,
    output logic [SLOT_W-1:0]                 slot_o,
    output logic                              found_o,
    output logic                              clash_o
);
    logic [NUM_SLOTS-1:0] other_busy;
    logic                 hit;
    logic                 free;
    logic [SLOT_W-1:0]    hit_idx;
    logic [SLOT_W-1:0]    free_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_busy
        assign other_busy[g] = (slot_pin_i[g] != pin_i) && (slot_pulse_i[g] != '0);
    end

    assign clash_o = (|other_busy) && (period_i != shared_per_i);

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (slot_pin_i[i] == pin_i) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
        end
        free     = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_pulse_i[i] == '0) begin
                free     = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
        slot_o  = hit ? hit_idx : free_idx;
        found_o = hit | free;
    end

endmodule

// File: rtl/pwm_cmp_bank.sv
// Shared counter advance and per-channel toggle events.
module pwm_cmp_bank #(
    parameter int NUM_SLOTS = 3,
    parameter int CNT_W     = 16
) (
    input  logic                            run_i,
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic [CNT_W-1:0]                per_cmp_i,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0] duty_cmp_i,
    input  logic [NUM_SLOTS-1:0]            chan_en_i,
    output logic [CNT_W-1:0]                cnt_next_o,
    output logic [NUM_SLOTS-1:0]            toggle_o
);
    logic [CNT_W:0] inc;
    logic           per_hit;

    assign inc     = {1'b0, cnt_i} + 1'b1;
    assign per_hit = run_i && (inc == {1'b0, per_cmp_i});

    always_comb begin
        if (!run_i) begin
            cnt_next_o = cnt_i;
        end else if (per_hit) begin
            cnt_next_o = '0;
        end else begin
            cnt_next_o = CNT_W'(inc);
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tog
        assign toggle_o[g] = run_i && chan_en_i[g] &&
                             ((inc == {1'b0, duty_cmp_i[g]}) ^ per_hit);
    end

endmodule

// File: rtl/pwm_share_ctrl.sv
module pwm_share_ctrl
    import pwm_share_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int CNT_W     = 16,
    parameter int PIN_W     = 5,
    parameter int VAL_W     = 32,
    localparam int NUM_PINS = 1 << PIN_W,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic [VAL_W-1:0]    req_period,
    input  logic [VAL_W-1:0]    req_pulse,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    output logic [NUM_PINS-1:0] pin_out
);
    typedef struct packed {
        logic                            run;
        logic [CNT_W-1:0]                cnt;
        logic [CNT_W-1:0]                per_cmp;
        logic [NUM_SLOTS-1:0][CNT_W-1:0] duty_cmp;
        logic [NUM_SLOTS-1:0]            chan_en;
        logic [NUM_SLOTS-1:0][PIN_W-1:0] chan_pin;
        logic [NUM_SLOTS-1:0][VAL_W-1:0] chan_pulse;
        logic [VAL_W-1:0]                shared_per;
        logic [NUM_PINS-1:0]             pins;
        logic                            rsp_v;
        pwm_status_e                     rsp_st;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [SLOT_W-1:0]    slot_sel;
    logic                 slot_found;
    logic                 per_clash;
    logic [CNT_W-1:0]     new_per_cmp;
    logic [CNT_W-1:0]     new_duty_cmp;
    logic [CNT_W-1:0]     cnt_next;
    logic [NUM_SLOTS-1:0] toggle;

    logic accept, pulse_zero, pulse_full, bypass, reject_arg, take;

    // monitor taps for the bound checker
    logic             run_mon;
    logic [CNT_W-1:0] cnt_mon;
    logic [CNT_W-1:0] per_mon;

    pwm_slot_alloc #(
        .NUM_SLOTS (NUM_SLOTS),
        .PIN_W     (PIN_W),
        .VAL_W     (VAL_W)
    ) u_alloc (
        .pin_i        (req_pin),
        .period_i     (req_period),
        .shared_per_i (state_q.shared_per),
        .slot_pin_i   (state_q.chan_pin),
        .slot_pulse_i (state_q.chan_pulse),
        .slot_o       (slot_sel),
        .found_o      (slot_found),
        .clash_o      (per_clash)
    );

    pwm_range_fit #(
        .VAL_W (VAL_W),
        .CNT_W (CNT_W)
    ) u_fit (
        .period_i   (req_period),
        .pulse_i    (req_pulse),
        .per_cmp_o  (new_per_cmp),
        .duty_cmp_o (new_duty_cmp)
    );

    pwm_cmp_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_cmp (
        .run_i      (state_q.run),
        .cnt_i      (state_q.cnt),
        .per_cmp_i  (state_q.per_cmp),
        .duty_cmp_i (state_q.duty_cmp),
        .chan_en_i  (state_q.chan_en),
        .cnt_next_o (cnt_next),
        .toggle_o   (toggle)
    );

    assign accept     = req_valid && !state_q.rsp_v;
    assign pulse_zero = (req_pulse == '0);
    assign pulse_full = !pulse_zero && (req_pulse == req_period);
    assign bypass     = pulse_zero || pulse_full;
    assign reject_arg = !bypass && per_clash;
    assign take       = accept && !reject_arg && slot_found;

    always_comb begin
        state_d       = state_q;
        state_d.rsp_v = 1'b0;

        if (take) begin
            // accepted: counter stops, slot routing dropped, pin parked
            state_d.run               = 1'b0;
            state_d.chan_en[slot_sel] = 1'b0;
            state_d.pins[req_pin]     = pulse_zero;
            if (bypass) begin
                state_d.chan_pulse[slot_sel] = '0;
            end else begin
                state_d.per_cmp              = new_per_cmp;
                state_d.duty_cmp[slot_sel]   = new_duty_cmp;
                state_d.cnt                  = '0;
                state_d.run                  = 1'b1;
                state_d.chan_en[slot_sel]    = 1'b1;
                state_d.chan_pin[slot_sel]   = req_pin;
                state_d.chan_pulse[slot_sel] = req_pulse;
                state_d.shared_per           = req_period;
            end
        end else begin
            state_d.cnt = cnt_next;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (toggle[i]) begin
                    state_d.pins[state_q.chan_pin[i]] = ~state_d.pins[state_q.chan_pin[i]];
                end
            end
        end

        if (accept) begin
            state_d.rsp_v = 1'b1;
            if (reject_arg) begin
                state_d.rsp_st = ST_BADARG;
            end else if (!slot_found) begin
                state_d.rsp_st = ST_NOSLOT;
            end else begin
                state_d.rsp_st = ST_OK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_ready  = !state_q.rsp_v;
    assign rsp_valid  = state_q.rsp_v;
    assign rsp_status = state_q.rsp_st;
    assign pin_out    = state_q.pins;

    assign run_mon = state_q.run;
    assign cnt_mon = state_q.cnt;
    assign per_mon = state_q.per_cmp;

endmodule

// File: rtl/pwm_share_chk.sv
module pwm_share_chk #(
    parameter int CNT_W = 16,
    parameter int PIN_W = 5,
    parameter int VAL_W = 32,
    localparam int NUM_PINS = 1 << PIN_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [PIN_W-1:0]    req_pin,
    input logic [VAL_W-1:0]    req_period,
    input logic [VAL_W-1:0]    req_pulse,
    input logic                rsp_valid,
    input logic [1:0]          rsp_status,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                run_mon,
    input logic [CNT_W-1:0]    cnt_mon,
    input logic [CNT_W-1:0]    per_mon
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_rsp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_status_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0 && $past(req_pulse) != '0 &&
         $past(req_pulse) != $past(req_period)) |-> !pin_out[$past(req_pin)]);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_mon |-> (cnt_mon < per_mon));

    assert_zero_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0 && $past(req_pulse) == '0)
        |-> (pin_out[$past(req_pin)] && !run_mon));

    assert_full_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0 && $past(req_pulse) != '0 &&
         $past(req_pulse) == $past(req_period))
        |-> (!pin_out[$past(req_pin)] && !run_mon));

    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_mon && !(req_valid && req_ready)) |=> $stable(pin_out));

    assert_badarg_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1)
        |-> ($past(req_pulse) != '0 && $past(req_pulse) != $past(req_period)));

endmodule

bind pwm_share_ctrl pwm_share_chk #(
    .CNT_W (CNT_W),
    .PIN_W (PIN_W),
    .VAL_W (VAL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pin    (req_pin),
    .req_period (req_period),
    .req_pulse  (req_pulse),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .pin_out    (pin_out),
    .run_mon    (run_mon),
    .cnt_mon    (cnt_mon),
    .per_mon    (per_mon)
);

// File: tb/pwm_share_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_share_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_pin = '0;
    logic [31:0] req_period = '0;
    logic [31:0] req_pulse = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] pin_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          t0 = 0;
    logic [31:0] pre_pins = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_share_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_pin    (req_pin),
        .req_period (req_period),
        .req_pulse  (req_pulse),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .pin_out    (pin_out)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
        end
    endtask

    function automatic logic lvl(input logic l0, input int n, input int p, input int d);
        return l0 ^ ((n % p) >= d);
    endfunction

    task automatic wait_to(input int n);
        while ((cyc - t0) < n) @(negedge clk);
    endtask

    task automatic wave(input int pin, input logic l0, input int p, input int d,
                        input int n_from, input int n_to, input string rq);
        for (int n = n_from; n <= n_to; n++) begin
            wait_to(n);
            check(rq, {31'b0, pin_out[pin]}, {31'b0, lvl(l0, n, p, d)});
        end
    endtask

    task automatic do_req(input logic [4:0] pin, input logic [31:0] per, input logic [31:0] pul,
                          input logic [1:0] exp_st, input string rq);
        while (req_ready !== 1'b1) @(negedge clk);
        pre_pins   = pin_out;
        req_pin    = pin;
        req_period = per;
        req_pulse  = pul;
        req_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 response valid", {31'b0, rsp_valid}, 32'd1);
        check("R1 ready low in response cycle", {31'b0, req_ready}, 32'd0);
        check(rq, {30'b0, rsp_status}, {30'b0, exp_st});
    endtask

    task automatic t_reset;
        check("R2 pins zero", pin_out, 32'd0);
        check("R2 no response", {31'b0, rsp_valid}, 32'd0);
        check("R2 ready high", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_single;
        do_req(5'd5, 32'd10, 32'd4, 2'd0, "R1 status ok");
        t0 = cyc;
        wave(5, 1'b0, 10, 4, 0, 0, "R3 start low");
        wait_to(1);
        check("R1 response one cycle", {31'b0, rsp_valid}, 32'd0);
        check("R1 ready back", {31'b0, req_ready}, 32'd1);
        wave(5, 1'b0, 10, 4, 1, 24, "R3 waveform");
        check("R11 other pins idle", pin_out & ~(32'd1 << 5), 32'd0);
    endtask

    task automatic t_second;
        logic l5;
        do_req(5'd9, 32'd10, 32'd6, 2'd0, "R10 second channel ok");
        t0 = cyc;
        l5 = pre_pins[5];
        wave(5, l5, 10, 4, 0, 19, "R10 running channel after restart");
        wave(9, 1'b0, 10, 6, 20, 39, "R3 second channel");
    endtask

    task automatic t_conflict;
        int a;
        logic l5;
        l5 = lvl(1'b0, 0, 10, 4);
        l5 = 1'b0;
        // pin5 level at last restart is recovered from the running formula
        l5 = pin_out[5] ^ lvl(1'b0, cyc - t0, 10, 4);
        do_req(5'd12, 32'd20, 32'd3, 2'd1, "R8 period clash rejected");
        a = cyc - t0;
        check("R8 rejected pin untouched", {31'b0, pin_out[12]}, 32'd0);
        wave(5, l5, 10, 4, a, a + 12, "R8 running waveform undisturbed");
    endtask

    task automatic t_slots;
        logic l5, l9;
        do_req(5'd12, 32'd10, 32'd2, 2'd0, "R9 last free slot");
        t0 = cyc;
        l5 = pre_pins[5];
        l9 = pre_pins[9];
        wave(12, 1'b0, 10, 2, 0, 9, "R9 third channel");
        wave(5, l5, 10, 4, 10, 14, "R10 channel a after restart");
        wave(9, l9, 10, 6, 15, 19, "R10 channel b after restart");
        do_req(5'd20, 32'd10, 32'd5, 2'd2, "R9 no free slot");
        check("R9 no slot pin untouched", {31'b0, pin_out[20]}, 32'd0);
        do_req(5'd5, 32'd10, 32'd7, 2'd0, "R9 same pin reuse");
        t0 = cyc;
        l9 = pre_pins[9];
        wave(5, 1'b0, 10, 7, 0, 19, "R9 reused slot new duty");
        wave(9, l9, 10, 6, 20, 29, "R10 neighbour continues");
    endtask

    task automatic t_zero;
        logic [31:0] snap;
        logic l5;
        do_req(5'd9, 32'd123, 32'd0, 2'd0, "R5 zero pulse ok despite period");
        check("R5 pin parked high", {31'b0, pin_out[9]}, 32'd1);
        snap = pin_out;
        repeat (20) @(negedge clk);
        check("R7 halted pins hold", pin_out, snap);
        do_req(5'd20, 32'd10, 32'd5, 2'd0, "R5 freed slot reused");
        t0 = cyc;
        l5 = pre_pins[5];
        wave(20, 1'b0, 10, 5, 0, 19, "R5 new channel in freed slot");
        wave(5, l5, 10, 7, 20, 29, "R10 channel after halt and restart");
        check("R11 parked pin keeps level", {31'b0, pin_out[9]}, 32'd1);
    endtask

    task automatic t_full;
        logic [31:0] snap;
        do_req(5'd12, 32'd777, 32'd777, 2'd0, "R6 full pulse ok despite period");
        check("R6 pin parked low", {31'b0, pin_out[12]}, 32'd0);
        snap = pin_out;
        repeat (20) @(negedge clk);
        check("R7 halted pins hold after full", pin_out, snap);
        do_req(5'd5, 32'd10, 32'd0, 2'd0, "R5 park pin5");
        do_req(5'd20, 32'd10, 32'd0, 2'd0, "R5 park pin20");
        check("R5 pin5 high", {31'b0, pin_out[5]}, 32'd1);
        check("R5 pin20 high", {31'b0, pin_out[20]}, 32'd1);
    endtask

    task automatic t_scale;
        do_req(5'd7, 32'h0002_0000, 32'h0000_8000, 2'd0, "R4 wide period accepted");
        t0 = cyc;
        // shift of 2: Pc = 32768, Dc = 8192
        wave(7, 1'b0, 32768, 8192, 8191, 8192, "R4 duty edge after shift");
        wave(7, 1'b0, 32768, 8192, 32767, 32768, "R4 period edge after shift");
        wave(7, 1'b0, 32768, 8192, 40959, 40960, "R4 second cycle");
        check("R11 parked pin9 still high", {31'b0, pin_out[9]}, 32'd1);
        do_req(5'd7, 32'd65535, 32'd65534, 2'd0, "R4 largest unshifted period");
        t0 = cyc;
        wave(7, 1'b0, 65535, 65534, 0, 0, "R4 unshifted start");
        wave(7, 1'b0, 65535, 65534, 65533, 65536, "R4 unshifted edges");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_second();
        t_conflict();
        t_slots();
        t_zero();
        t_full();
        t_scale();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule